// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit data pointers and a one-bit pointer select. The special-function-register (SFR) bus reaches all of them, and each pointer byte and the select register have a fixed byte address there. The processor core has a second, narrower port. Through it the core loads the active pointer with a full 16-bit value or increments it by one. The same port gives the active pointer back as the address for external data accesses.

The select register is the only state that decides which pointer is active. Only bit 0 is stored and the upper bits read as zero. A read-modify-write increment of that register therefore flips the selection. Software uses this to alternate between a source pointer and a destination pointer during a block move with a single instruction.

The select bit is held in a two-state machine:
- `SEL_PTR0` is the reset state. The first pointer is active.
- `SEL_PTR1`: the second pointer is active.
- The transition `SEL_PTR0 -> SEL_PTR1` occurs on an SFR write to the select address with data bit 0 = 1.
- The transition `SEL_PTR1 -> SEL_PTR0` occurs on such a write with data bit 0 = 0.
- Any other cycle keeps the current state.

Top module: `dptr_unit`

## Requirements
- R1: After reset both pointers hold 0000h and the select state is `SEL_PTR0`, so 86h reads 00h and `core_addr` is 0000h.
- R2: The first pointer's low and high bytes sit at SFR addresses 82h and 83h. The second pointer's low and high bytes sit at 84h and 85h. A write changes exactly the addressed byte in the next cycle, and a read returns the current byte in the same cycle.
- R3: Address 86h stores only bit 0 as the select bit (0 = first pointer, 1 = second pointer). Bits 7..1 always read 0 and writes to them are ignored. As a result, reading 86h, adding 1 and writing the sum back toggles the selection.
- R4: `core_addr` always equals the pointer named by the current select state.
- R5: `core_load` replaces the whole active pointer with `core_load_val` in the next cycle. The inactive pointer does not change.
- R6: `core_inc` adds 1 to the active pointer, wrapping from FFFFh to 0000h. The inactive pointer does not change.
- R7: When `core_load` and `core_inc` are both asserted, the load takes effect and the increment does not.
- R8: When an SFR byte write and a core load or increment hit the same pointer in one cycle, the core operation wins. An SFR write to the other pointer in that cycle still takes effect. A core operation in the same cycle as a write to 86h acts on the pointer selected before that write.
- R9: `sfr_rdata` is 00h when `sfr_rd` is low or when the address is not one of 82h–86h. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR byte address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational |
| core_load | input | 1 | Load active pointer from `core_load_val` |
| core_load_val | input | 16 | Value for a core load |
| core_inc | input | 1 | Increment active pointer |
| core_addr | output | 16 | Active pointer, used as access address |

## Verification
The bench builds the unit with its default parameters: 8-bit data and address, 16-bit pointers, and the register map at 82h–86h. With 16-bit pointers a core load of FFFEh brings the FFFFh-to-0000h wrap within two increments. The 8-bit data width means the select register has seven constant bits whose write-masking can be observed. A block move that crosses the wrap on the source pointer exercises toggling by read-increment-write. Random mixes of SFR traffic and core operations hit the collision priorities.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    // Which pointer is active
    typedef enum logic {
        SEL_PTR0 = 1'b0,
        SEL_PTR1 = 1'b1
    } sel_state_e;

    // Default SFR map; the select address is where the toggle-by-increment trick lives
    localparam logic [7:0] P0_LO_DEF = 8'h82;
    localparam logic [7:0] P0_HI_DEF = 8'h83;
    localparam logic [7:0] P1_LO_DEF = 8'h84;
    localparam logic [7:0] P1_HI_DEF = 8'h85;
    localparam logic [7:0] SEL_DEF   = 8'h86;
endpackage

// File: rtl/dptr_select.sv
module dptr_select
    import dptr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic              sel_idx,
    output logic [DATA_W-1:0] rd_byte
);
    sel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_PTR0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_PTR0: if (wr_en && wr_bit)  state_d = SEL_PTR1;
            SEL_PTR1: if (wr_en && !wr_bit) state_d = SEL_PTR0;
            default:                        state_d = SEL_PTR0;
        endcase
    end

    always_comb begin
        sel_idx = 1'b0;
        unique case (state_q)
            SEL_PTR0: sel_idx = 1'b0;
            SEL_PTR1: sel_idx = 1'b1;
            default:  sel_idx = 1'b0;
        endcase
        rd_byte = {{(DATA_W-1){1'b0}}, sel_idx};
    end
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg #(
    parameter int DATA_W = 8,
    localparam int PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              inc,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  value
);
    logic [PTR_W-1:0] nxt;

    // Core operations take precedence over byte writes from the SFR bus
    always_comb begin
        nxt = value;
        if (ld) begin
            nxt = ld_val;
        end else if (inc) begin
            nxt = value + PTR_W'(1);
        end else begin
            if (wr_lo) nxt[DATA_W-1:0]     = wdata;
            if (wr_hi) nxt[PTR_W-1:DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else        value <= nxt;
    end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
    import dptr_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] P0_LO_ADDR = ADDR_W'(P0_LO_DEF),
    parameter logic [ADDR_W-1:0] P0_HI_ADDR = ADDR_W'(P0_HI_DEF),
    parameter logic [ADDR_W-1:0] P1_LO_ADDR = ADDR_W'(P1_LO_DEF),
    parameter logic [ADDR_W-1:0] P1_HI_ADDR = ADDR_W'(P1_HI_DEF),
    parameter logic [ADDR_W-1:0] SEL_ADDR   = ADDR_W'(SEL_DEF),
    localparam int PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              core_load,
    input  logic [PTR_W-1:0]  core_load_val,
    input  logic              core_inc,
    output logic [PTR_W-1:0]  core_addr
);
    localparam int NPTR = 2;

    logic              sel_idx;
    logic [DATA_W-1:0] sel_byte;
    logic [PTR_W-1:0]  ptr_val [NPTR];

    dptr_select #(.DATA_W(DATA_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sfr_wr && (sfr_addr == SEL_ADDR)),
        .wr_bit  (sfr_wdata[0]),
        .sel_idx (sel_idx),
        .rd_byte (sel_byte)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam logic [ADDR_W-1:0] LO_A = (g == 0) ? P0_LO_ADDR : P1_LO_ADDR;
        localparam logic [ADDR_W-1:0] HI_A = (g == 0) ? P0_HI_ADDR : P1_HI_ADDR;
        logic active;
        assign active = (sel_idx == 1'(g));

        dptr_reg #(.DATA_W(DATA_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (active && core_load),
            .inc    (active && core_inc),
            .ld_val (core_load_val),
            .wr_lo  (sfr_wr && (sfr_addr == LO_A)),
            .wr_hi  (sfr_wr && (sfr_addr == HI_A)),
            .wdata  (sfr_wdata),
            .value  (ptr_val[g])
        );
    end

    assign core_addr = ptr_val[sel_idx];

    always_comb begin
        sfr_rdata = '0;
        if (sfr_rd) begin
            if      (sfr_addr == P0_LO_ADDR) sfr_rdata = ptr_val[0][DATA_W-1:0];
            else if (sfr_addr == P0_HI_ADDR) sfr_rdata = ptr_val[0][PTR_W-1:DATA_W];
            else if (sfr_addr == P1_LO_ADDR) sfr_rdata = ptr_val[1][DATA_W-1:0];
            else if (sfr_addr == P1_HI_ADDR) sfr_rdata = ptr_val[1][PTR_W-1:DATA_W];
            else if (sfr_addr == SEL_ADDR)   sfr_rdata = sel_byte;
        end
    end
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86,
    localparam int PTR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic              sfr_rd,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              core_load,
    input logic [PTR_W-1:0]  core_load_val,
    input logic              core_inc,
    input logic [PTR_W-1:0]  core_addr,
    input logic              sel_idx
);
    logic sel_wr;
    assign sel_wr = sfr_wr && (sfr_addr == SEL_ADDR);

    // R3: upper select bits never read as one
    a_r3_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == SEL_ADDR) |-> (sfr_rdata[DATA_W-1:1] == '0));

    // R3: select state follows written bit 0
    a_r3_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_idx == $past(sfr_wdata[0])));

    // R5 and R7: load sets the active pointer, even with increment asserted
    a_r5_load_active: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load && !sel_wr) |=> (core_addr == $past(core_load_val)));

    // R6: increment wraps modulo 2^PTR_W
    a_r6_inc_active: assert property (@(posedge clk) disable iff (!rst_n)
        (core_inc && !core_load && !sel_wr) |=> (core_addr == $past(core_addr) + PTR_W'(1)));

    // R9: no read strobe, no data
    a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_rd |-> (sfr_rdata == '0));

    // R4: active pointer holds when nothing writes
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sfr_wr && !core_load && !core_inc) |=> $stable(core_addr));
endmodule

bind dptr_unit dptr_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .core_load(core_load),
    .core_load_val(core_load_val), .core_inc(core_inc), .core_addr(core_addr),
    .sel_idx(sel_idx)
);

// File: tb/dptr_unit_tb_top.sv
module dptr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0, sfr_rd = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        core_load = 1'b0, core_inc = 1'b0;
    logic [15:0] core_load_val = '0;
    logic [15:0] core_addr;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    logic [15:0] m_ptr [2];
    logic        m_sel;

    always #2.5 clk = ~clk;

    dptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .core_load(core_load),
        .core_load_val(core_load_val), .core_inc(core_inc), .core_addr(core_addr)
    );

    function automatic logic [7:0] exp_read(input logic rd, input logic [7:0] a);
        if (!rd) return 8'h00;
        case (a)
            8'h82: return m_ptr[0][7:0];
            8'h83: return m_ptr[0][15:8];
            8'h84: return m_ptr[1][7:0];
            8'h85: return m_ptr[1][15:8];
            8'h86: return {7'b0, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_req(input logic [7:0] a);
        if (a >= 8'h82 && a <= 8'h85) return "R2";
        if (a == 8'h86) return "R3";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, update model at posedge
    task automatic cyc(input logic wr, input logic rd, input logic [7:0] a, input logic [7:0] wd,
                       input logic ld, input logic [15:0] lv, input logic inc,
                       output logic [7:0] rdv);
        logic act;
        @(negedge clk);
        sfr_wr = wr; sfr_rd = rd; sfr_addr = a; sfr_wdata = wd;
        core_load = ld; core_load_val = lv; core_inc = inc;
        #1;
        rdv = sfr_rdata;
        check(rd_req(a), {8'h00, sfr_rdata}, {8'h00, exp_read(rd, a)});
        check("R4", core_addr, m_ptr[m_sel]);
        @(posedge clk);
        act = m_sel;
        if (ld)       m_ptr[act] = lv;
        else if (inc) m_ptr[act] = m_ptr[act] + 16'd1;
        if (wr) begin
            case (a)
                8'h82: if (!(act == 1'b0 && (ld || inc))) m_ptr[0][7:0]  = wd;
                8'h83: if (!(act == 1'b0 && (ld || inc))) m_ptr[0][15:8] = wd;
                8'h84: if (!(act == 1'b1 && (ld || inc))) m_ptr[1][7:0]  = wd;
                8'h85: if (!(act == 1'b1 && (ld || inc))) m_ptr[1][15:8] = wd;
                8'h86: m_sel = wd[0];
                default: ;
            endcase
        end
    endtask

    task automatic idle();
        logic [7:0] d;
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b0, d);
    endtask

    // Toggle selection by read, add one, write back (R3)
    task automatic toggle_sel();
        logic [7:0] d;
        cyc(1'b0, 1'b1, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, d);
        cyc(1'b1, 1'b0, 8'h86, d + 8'd1, 1'b0, 16'h0, 1'b0, d);
    endtask

    task automatic rd_ptr(input int idx, input string req, input logic [15:0] exp);
        logic [7:0] lo, hi;
        cyc(1'b0, 1'b1, (idx == 0) ? 8'h82 : 8'h84, 8'h00, 1'b0, 16'h0, 1'b0, lo);
        cyc(1'b0, 1'b1, (idx == 0) ? 8'h83 : 8'h85, 8'h00, 1'b0, 16'h0, 1'b0, hi);
        check(req, {hi, lo}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [15:0] src, dst;
        m_ptr[0] = '0; m_ptr[1] = '0; m_sel = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1", core_addr, 16'h0000);
        rd_ptr(0, "R1", 16'h0000);
        rd_ptr(1, "R1", 16'h0000);
        cyc(1'b0, 1'b1, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, d);
        check("R1", {8'h00, d}, 16'h0000);

        // R2: byte writes
        cyc(1'b1, 1'b0, 8'h82, 8'h34, 1'b0, 16'h0, 1'b0, d);
        cyc(1'b1, 1'b0, 8'h85, 8'hAB, 1'b0, 16'h0, 1'b0, d);
        rd_ptr(0, "R2", 16'h0034);
        rd_ptr(1, "R2", 16'hAB00);

        // R3: upper bits masked, select follows bit 0
        cyc(1'b1, 1'b0, 8'h86, 8'hFE, 1'b0, 16'h0, 1'b0, d);
        cyc(1'b0, 1'b1, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, d);
        check("R3", {8'h00, d}, 16'h0000);
        cyc(1'b1, 1'b0, 8'h86, 8'hFF, 1'b0, 16'h0, 1'b0, d);
        cyc(1'b0, 1'b1, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, d);
        check("R3", {8'h00, d}, 16'h0001);

        // R5, R7: load with increment on second pointer only
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 16'h1234, 1'b1, d);
        idle();
        check("R7", core_addr, 16'h1234);
        rd_ptr(0, "R5", 16'h0034);

        // R8: collision with active pointer and concurrent write to the other
        cyc(1'b1, 1'b0, 8'h84, 8'h55, 1'b0, 16'h0, 1'b1, d);
        cyc(1'b1, 1'b0, 8'h82, 8'h77, 1'b1, 16'hBEEF, 1'b0, d);
        rd_ptr(1, "R8", 16'hBEEF);
        rd_ptr(0, "R8", 16'h0077);
        // core op in same cycle as select write uses old selection
        cyc(1'b1, 1'b0, 8'h86, 8'h00, 1'b0, 16'h0, 1'b1, d);
        rd_ptr(1, "R8", 16'hBEF0);
        check("R8", core_addr, 16'h0077);

        // R9: unmapped write and read
        cyc(1'b1, 1'b0, 8'h81, 8'hFF, 1'b0, 16'h0, 1'b0, d);
        cyc(1'b0, 1'b1, 8'h81, 8'h00, 1'b0, 16'h0, 1'b0, d);
        check("R9", {8'h00, d}, 16'h0000);
        rd_ptr(0, "R9", 16'h0077);

        // R6: block move across wrap
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 16'hFFFE, 1'b0, d);
        toggle_sel();
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 16'h2000, 1'b0, d);
        toggle_sel();
        src = 16'hFFFE; dst = 16'h2000;
        for (int i = 0; i < 4; i++) begin
            idle();
            check("R6", core_addr, src);
            cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, d);
            src = src + 16'd1;
            toggle_sel();
            idle();
            check("R6", core_addr, dst);
            cyc(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, d);
            dst = dst + 16'd1;
            toggle_sel();
        end
        rd_ptr(0, "R6", 16'h0002);
        rd_ptr(1, "R6", 16'h2004);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] a;
            a = 8'h80 + 8'($urandom_range(0, 7));
            cyc(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), a, 8'($urandom),
                1'($urandom_range(0, 5) == 0), 16'($urandom), 1'($urandom_range(0, 3) == 0), d);
        end
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule